// File: doc/BRIEF.md
# Indexed Palette Lookup Table with Host Load Port

This block turns an 8-bit pixel index into a 24-bit RGB colour. A table of 256 entries holds three 8-bit components per entry. The display side presents one pixel index per clock. The index is first ANDed with a programmable plane mask. The looked-up colour then appears one clock later, on a registered output.

A host loads the table through a narrow port of 32-bit write words. Every 8-bit value rides in the top byte of the word, bits 31:24. The host first writes an entry number to the index register. It then writes three words to the colour-data register: red, then green, then blue. After the blue word the entry is stored, and the index moves on by one, wrapping from 255 to 0. Consecutive entries can therefore be streamed without rewriting the index.

The same index register also selects a small bank of configuration registers at indexes 4 to 7. A word written to the control register lands in the selected bank register:
- index 4 is the plane mask;
- index 6 is a mode byte that is brought out for a downstream overlay stage;
- indexes 5 and 7 are spare.

Both streams use a valid/ready handshake:
- **Host port.** A word is taken on any clock where `host_valid` and `host_ready` are both high. `host_ready` is low only while reset is held and for the first clock after it, and high at all other times. The port never applies back-pressure otherwise.
- **Pixel stream.** The pixel stream has no ready signal, because display timing cannot stall. Every `pix_valid` beat produces exactly one `rgb_valid` beat one clock later.

Top module: `pal_lut_top`

## Requirements
- R1: After reset: `rgb_valid` is 0 and `rgb_out` is 0. Every table entry reads as 0. The plane mask is 0xFF and `cfg_mode` is 0x73. `host_ready` is 0 while reset is held and goes to 1 after release.
- R2: A word accepted with `host_sel` = 0 loads the entry index from bits 31:24 of `host_wdata`.
- R3: Three words accepted with `host_sel` = 1 carry red, green and blue, in that order, each in bits 31:24; bits 23:0 are ignored. The stored entry reads back on `rgb_out` as {red[23:16], green[15:8], blue[7:0]}.
- R4: An entry is written into the table only when its blue word is accepted. After only red, or only red and green, a lookup of that entry still returns its previous colour.
- R5: Accepting a blue word advances the entry index by one, and index 255 wraps to 0.
- R6: Accepting a word with `host_sel` = 0 resets the component sequence to red, discarding any partly loaded colour.
- R7: A word accepted with `host_sel` = 2 writes bits 31:24 into the configuration register selected by the current index, when that index is 4 to 7:
  - index 4 is the plane mask;
  - index 6 drives `cfg_mode`;
  - with any other index the write has no effect;
  - the write does not change the entry index.
- R8: The table is addressed with `pix_index` AND plane mask.
- R9: For each `pix_valid` beat, `rgb_valid` is 1 with the looked-up colour on the following clock. Without a beat, `rgb_valid` is 0 and `rgb_out` holds its last value.
- R10: Words with `host_sel` = 3, and words presented while `host_valid` is 0, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host write word present |
| host_ready | output | 1 | Host port accepts words |
| host_sel | input | 2 | Target: 0 index, 1 colour data, 2 control, 3 none |
| host_wdata | input | 32 | Write word, value in bits 31:24 |
| pix_valid | input | 1 | Pixel index present |
| pix_index | input | 8 | Pixel index |
| rgb_valid | output | 1 | Colour output valid |
| rgb_out | output | 24 | Looked-up colour {R,G,B} |
| cfg_mode | output | 8 | Configuration register at index 6 |

## Verification
The table is loaded in several ways:
- single entries written with junk in the low bits of each word, which separates correct use of the top byte from a wrong lane;
- streamed runs across the 255-to-0 wrap, which exposes increment and wrap faults;
- a sequence interrupted by an index rewrite, which distinguishes restart-to-red from sequence continuation.

Lookups taken between component writes reveal early commits. Masked lookups of an index whose low bits differ from a known entry expose a missing or misplaced AND. Control writes at index 6 and at index 3 show whether only the correct register moves. Idle gaps and back-to-back beats on the pixel stream check the one-clock latency and the output hold.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    SEL_INDEX = 2'd0,
    SEL_CDATA = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } host_sel_e;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } comp_phase_e;
endpackage

// File: rtl/pal_host_if.sv
module pal_host_if
  import pal_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int COMP_W   = 8,
  parameter int BUS_W    = 32,
  parameter int CFG_BASE = 4,
  parameter int CFG_N    = 4,
  parameter logic [CFG_N*COMP_W-1:0] CFG_INIT = 32'h00_73_00_FF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_valid,
  output logic                    host_ready,
  input  logic [1:0]              host_sel,
  input  logic [BUS_W-1:0]        host_wdata,
  output logic                    wr_en,
  output logic [IDX_W-1:0]        wr_addr,
  output logic [3*COMP_W-1:0]     wr_rgb,
  output logic [CFG_N*COMP_W-1:0] cfg_flat
);
  localparam int LANE_LSB = BUS_W - COMP_W;

  logic [COMP_W-1:0] lane;
  logic              take;
  logic [IDX_W-1:0]  idx_q;
  comp_phase_e       phase_q;
  logic [COMP_W-1:0] red_q, grn_q;
  logic              ctrl_hit;

  assign lane     = host_wdata[BUS_W-1:LANE_LSB];
  assign take     = host_valid && host_ready;
  assign ctrl_hit = (int'(idx_q) >= CFG_BASE) && (int'(idx_q) < CFG_BASE + CFG_N);

  always_ff @(posedge clk) begin
    if (!rst_n) host_ready <= 1'b0;
    else        host_ready <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      phase_q <= PH_RED;
      red_q   <= '0;
      grn_q   <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_rgb  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (take && host_sel == SEL_INDEX) begin
        idx_q   <= lane[IDX_W-1:0];
        phase_q <= PH_RED;
      end else if (take && host_sel == SEL_CDATA) begin
        unique case (phase_q)
          PH_RED:   begin red_q <= lane; phase_q <= PH_GREEN; end
          PH_GREEN: begin grn_q <= lane; phase_q <= PH_BLUE;  end
          default: begin
            wr_en   <= 1'b1;
            wr_addr <= idx_q;
            wr_rgb  <= {red_q, grn_q, lane};
            idx_q   <= idx_q + 1'b1;
            phase_q <= PH_RED;
          end
        endcase
      end
    end
  end

  for (genvar g = 0; g < CFG_N; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n)
        cfg_flat[g*COMP_W +: COMP_W] <= CFG_INIT[g*COMP_W +: COMP_W];
      else if (take && host_sel == SEL_CTRL && ctrl_hit &&
               int'(idx_q) == CFG_BASE + g)
        cfg_flat[g*COMP_W +: COMP_W] <= lane;
    end
  end

  a_r5_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (take && host_sel == SEL_CDATA && phase_q == PH_BLUE) |=> idx_q == $past(idx_q) + 1'b1);

  a_r6_index_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (take && host_sel == SEL_INDEX) |=> phase_q == PH_RED);

  a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && host_sel == SEL_CTRL) |=> $stable(cfg_flat));

  a_r10_none_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_valid || host_sel == SEL_NONE) |=> ($stable(idx_q) && $stable(phase_q) && !wr_en));
endmodule

// File: rtl/pal_table.sv
module pal_table #(
  parameter int IDX_W = 8,
  parameter int RGB_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [RGB_W-1:0] wr_rgb,
  input  logic             rd_valid,
  input  logic [IDX_W-1:0] rd_addr,
  output logic             out_valid,
  output logic [RGB_W-1:0] out_rgb
);
  localparam int DEPTH = 1 << IDX_W;

  logic [RGB_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_rgb;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= rd_valid;
      if (rd_valid) out_rgb <= mem[rd_addr];
    end
  end

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> out_valid);

  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !out_valid);

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> $stable(out_rgb));
endmodule

// File: rtl/pal_lut_top.sv
module pal_lut_top
  import pal_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int COMP_W   = 8,
  parameter int BUS_W    = 32,
  parameter int CFG_BASE = 4,
  parameter int CFG_N    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_valid,
  output logic                host_ready,
  input  logic [1:0]          host_sel,
  input  logic [BUS_W-1:0]    host_wdata,
  input  logic                pix_valid,
  input  logic [IDX_W-1:0]    pix_index,
  output logic                rgb_valid,
  output logic [3*COMP_W-1:0] rgb_out,
  output logic [COMP_W-1:0]   cfg_mode
);
  localparam int RGB_W    = 3 * COMP_W;
  localparam int MASK_SLOT = 0;
  localparam int MODE_SLOT = 2;

  logic                    wr_en;
  logic [IDX_W-1:0]        wr_addr;
  logic [RGB_W-1:0]        wr_rgb;
  logic [CFG_N*COMP_W-1:0] cfg_flat;
  logic [IDX_W-1:0]        plane_mask;
  logic [IDX_W-1:0]        masked_idx;

  pal_host_if #(
    .IDX_W(IDX_W), .COMP_W(COMP_W), .BUS_W(BUS_W),
    .CFG_BASE(CFG_BASE), .CFG_N(CFG_N)
  ) u_host (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_ready(host_ready),
    .host_sel(host_sel), .host_wdata(host_wdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_rgb(wr_rgb),
    .cfg_flat(cfg_flat)
  );

  assign plane_mask = cfg_flat[MASK_SLOT*COMP_W +: IDX_W];
  assign cfg_mode   = cfg_flat[MODE_SLOT*COMP_W +: COMP_W];
  assign masked_idx = pix_index & plane_mask;

  pal_table #(.IDX_W(IDX_W), .RGB_W(RGB_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_rgb(wr_rgb),
    .rd_valid(pix_valid), .rd_addr(masked_idx),
    .out_valid(rgb_valid), .out_rgb(rgb_out)
  );

  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> host_ready);

  a_r7_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_valid && host_sel == SEL_CTRL) |=> $stable(cfg_mode));
endmodule

// File: tb/sim_pal_lut_top.sv
`timescale 1ns/1ps
module sim_pal_lut_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0;
  logic        host_ready;
  logic [1:0]  host_sel = 2'd0;
  logic [31:0] host_wdata = '0;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_index = '0;
  logic        rgb_valid;
  logic [23:0] rgb_out;
  logic [7:0]  cfg_mode;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pal_lut_top u0 (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_sel(host_sel), .host_wdata(host_wdata), .pix_valid(pix_valid),
    .pix_index(pix_index), .rgb_valid(rgb_valid), .rgb_out(rgb_out),
    .cfg_mode(cfg_mode)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    host_valid = 1'b1; host_sel = sel; host_wdata = data;
    @(negedge clk);
    host_valid = 1'b0; host_sel = 2'd3; host_wdata = 32'hDEAD_BEEF;
  endtask

  task automatic load_rgb(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    hwrite(2'd1, {r, 24'hA5C3_1F});
    hwrite(2'd1, {g, 24'h5A3C_E0});
    hwrite(2'd1, {b, 24'hFFFF_FF});
  endtask

  task automatic lookup(input string tag, input logic [7:0] idx, input logic [23:0] exp);
    @(negedge clk);
    pix_valid = 1'b1; pix_index = idx;
    @(negedge clk);
    pix_valid = 1'b0;
    check({tag, " valid"}, {31'd0, rgb_valid}, 32'd1);
    check(tag, {8'd0, rgb_out}, {8'd0, exp});
  endtask

  task automatic t_reset();
    check("R1 ready low in reset", {31'd0, host_ready}, 32'd0);
    check("R1 rgb_valid reset", {31'd0, rgb_valid}, 32'd0);
    check("R1 rgb_out reset", {8'd0, rgb_out}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 ready after reset", {31'd0, host_ready}, 32'd1);
    check("R1 cfg_mode init", {24'd0, cfg_mode}, 32'h73);
    lookup("R1 table zero", 8'h10, 24'h0);
    lookup("R1 mask all planes", 8'hFF, 24'h0);
  endtask

  task automatic t_single();
    hwrite(2'd0, 32'h10_FFFFFF);
    hwrite(2'd1, 32'h11_0000FF);
    lookup("R4 after red", 8'h10, 24'h0);
    hwrite(2'd1, 32'h22_123456);
    lookup("R4 after green", 8'h10, 24'h0);
    hwrite(2'd1, 32'h33_ABCDEF);
    lookup("R3 entry stored", 8'h10, 24'h112233);
    lookup("R2 neighbour untouched", 8'h0F, 24'h0);
  endtask

  task automatic t_stream_wrap();
    load_rgb(8'h44, 8'h55, 8'h66);
    lookup("R5 next entry", 8'h11, 24'h445566);
    hwrite(2'd0, 32'hFF_000000);
    load_rgb(8'h01, 8'h02, 8'h03);
    load_rgb(8'h0A, 8'h0B, 8'h0C);
    lookup("R5 entry 255", 8'hFF, 24'h010203);
    lookup("R5 wrap to 0", 8'h00, 24'h0A0B0C);
  endtask

  task automatic t_restart();
    hwrite(2'd0, 32'h20_000000);
    hwrite(2'd1, 32'hAA_000000);
    hwrite(2'd1, 32'hBB_000000);
    hwrite(2'd0, 32'h20_000000);
    load_rgb(8'hC1, 8'hC2, 8'hC3);
    lookup("R6 restart at red", 8'h20, 24'hC1C2C3);
    lookup("R6 no spill", 8'h21, 24'h0);
  endtask

  task automatic t_ignore();
    hwrite(2'd0, 32'h30_000000);
    hwrite(2'd1, 32'h44_000000);
    hwrite(2'd3, 32'h99_000000);
    @(negedge clk);
    host_valid = 1'b0; host_sel = 2'd1; host_wdata = 32'h88_000000;
    @(negedge clk);
    host_sel = 2'd3;
    hwrite(2'd1, 32'h66_000000);
    hwrite(2'd1, 32'h77_000000);
    lookup("R10 ignored words", 8'h30, 24'h446677);
  endtask

  task automatic t_mask_cfg();
    hwrite(2'd0, 32'h04_000000);
    hwrite(2'd2, 32'hF0_000000);
    lookup("R8 masked lookup", 8'h1F, 24'h112233);
    hwrite(2'd0, 32'h06_000000);
    hwrite(2'd2, 32'h5A_000000);
    @(negedge clk);
    check("R7 mode written", {24'd0, cfg_mode}, 32'h5A);
    lookup("R7 mask kept after idx6", 8'h1F, 24'h112233);
    hwrite(2'd0, 32'h03_000000);
    hwrite(2'd2, 32'h00_000000);
    lookup("R7 idx3 ignored", 8'h1F, 24'h112233);
    check("R7 mode kept", {24'd0, cfg_mode}, 32'h5A);
    hwrite(2'd0, 32'h04_000000);
    hwrite(2'd2, 32'hFF_000000);
    hwrite(2'd2, 32'hFF_000000);
    load_rgb(8'hD1, 8'hD2, 8'hD3);
    lookup("R7 ctrl keeps index", 8'h04, 24'hD1D2D3);
    lookup("R8 mask restored", 8'h1F, 24'h0);
  endtask

  task automatic t_stream_out();
    @(negedge clk);
    pix_valid = 1'b1; pix_index = 8'h10;
    @(negedge clk);
    check("R9 beat1", {8'd0, rgb_out}, 32'h112233);
    pix_index = 8'h11;
    @(negedge clk);
    check("R9 beat2", {8'd0, rgb_out}, 32'h445566);
    check("R9 beat2 valid", {31'd0, rgb_valid}, 32'd1);
    pix_valid = 1'b0; pix_index = 8'h20;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 idle valid low", {31'd0, rgb_valid}, 32'd0);
      check("R9 idle hold", {8'd0, rgb_out}, 32'h445566);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_single();
    t_stream_wrap();
    t_restart();
    t_ignore();
    t_mask_cfg();
    t_stream_out();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule